// File: doc/BRIEF.md
# Crossbar Barrel Shifter

This block is the single-pass operand shifter of a processor datapath. It takes a 32-bit operand and moves it by any amount from 0 to 31 in one combinational pass. The shift can be a logical left shift, a logical right shift, an arithmetic right shift or a rotate right. It also produces the shifter carry, which is the last bit moved out of the word.

Bit selection is modelled as a square switch matrix. Each shift amount and direction enables one diagonal of that matrix. An output bit that no enabled switch reaches reads as zero, and this supplies the zero fill that logical shifts need. A rotate enables one right diagonal and its complementary left diagonal together, and their contributions are ORed. For an arithmetic shift, a separate decoder derives from the amount which upper bits were vacated and forces them to the sign bit.

The block has no clock and no registers, because it lies on the critical path of the execute cycle.

Top module: `xbar_barrel_shifter`

## Requirements
- R1: Shift type 2'b00 selects logical left shift. For amount n the result is the operand shifted left by n, and bits n-1..0 are zero.
- R2: An amount of 0 returns the operand unchanged for every shift type, and carry_o then equals carry_i.
- R3: Shift type 2'b01 selects logical right shift. The result is the operand shifted right by n, and the top n bits are zero.
- R4: Shift type 2'b10 selects arithmetic right shift. The result is the operand shifted right by n, and the top n bits are copies of operand bit 31.
- R5: Shift type 2'b11 selects rotate right. Result bit j equals operand bit (j+n) mod 32.
- R6: For logical left shift with n not 0, carry_o equals operand bit 32-n.
- R7: For the three right-going types with n not 0, carry_o equals operand bit n-1.
- R8: The block is purely combinational. The outputs follow the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to shift |
| amount_i | input | 5 | Shift distance 0..31 |
| kind_i | input | 2 | Shift type: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_i | input | 1 | Incoming carry, passed through when the amount is zero |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Last bit shifted out, or carry_i |

## Verification
Immediate assertions in the bound checker are evaluated whenever the inputs change. They check the following local invariants:
- a zero amount is an identity;
- the fill bit is zero for a logical left shift and for a logical right shift;
- the sign bit is preserved by an arithmetic shift;
- a rotation keeps the population count, and its top result bit equals the carry;
- the carry for right-going shifts is taken from bit n-1.

Only the bench's exhaustive sweep shows that the whole result word is correct. It compares every type at every amount against an arithmetic reference, on corner operands and random operands. The same sweep is the only check of the left-shift carry position, and of the outputs settling before any clock edge.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL = 2'b00,
    SHF_LSR = 2'b01,
    SHF_ASR = 2'b10,
    SHF_ROR = 2'b11
  } shf_kind_e;
endpackage

// File: rtl/shf_diag_decode.sv
// Picks which diagonals of the switch matrix conduct.
module shf_diag_decode
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  shf_kind_e        kind_i,
  input  logic [AMT_W-1:0] amount_i,
  output logic [WIDTH-1:0] right_en_o,
  output logic [WIDTH-1:0] left_en_o
);
  logic [AMT_W-1:0] comp_amt;

  // WIDTH is a power of two, so 0 - n wraps to WIDTH - n
  assign comp_amt = AMT_W'(0) - amount_i;

  always_comb begin
    right_en_o = '0;
    left_en_o  = '0;
    unique case (kind_i)
      SHF_LSL: left_en_o[amount_i] = 1'b1;
      SHF_LSR,
      SHF_ASR: right_en_o[amount_i] = 1'b1;
      SHF_ROR: begin
        right_en_o[amount_i] = 1'b1;
        if (amount_i != '0) left_en_o[comp_amt] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shf_xbar_matrix.sv
// Square switch matrix; undriven outputs fall to zero.
module shf_xbar_matrix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] right_en_i,
  input  logic [WIDTH-1:0] left_en_i,
  output logic [WIDTH-1:0] data_o
);
  for (genvar j = 0; j < WIDTH; j++) begin : g_out
    logic [WIDTH-1:0] r_term;
    logic [WIDTH-1:0] l_term;
    for (genvar k = 0; k < WIDTH; k++) begin : g_sw
      if (j + k < WIDTH) begin : g_r
        assign r_term[k] = right_en_i[k] & data_i[j+k];
      end else begin : g_r0
        assign r_term[k] = 1'b0;
      end
      if (j >= k) begin : g_l
        assign l_term[k] = left_en_i[k] & data_i[j-k];
      end else begin : g_l0
        assign l_term[k] = 1'b0;
      end
    end
    assign data_o[j] = (|r_term) | (|l_term);
  end
endmodule

// File: rtl/shf_sign_fill.sv
// Decodes the amount into the set of vacated upper bits for an arithmetic shift.
module shf_sign_fill #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             asr_i,
  input  logic             sign_i,
  input  logic [AMT_W-1:0] amount_i,
  output logic [WIDTH-1:0] fill_o
);
  logic active;
  assign active = asr_i & sign_i;

  for (genvar j = 0; j < WIDTH; j++) begin : g_fill
    // bit j is vacated when j >= WIDTH - n, i.e. n > WIDTH-1-j
    assign fill_o[j] = active & ({1'b0, amount_i} > (AMT_W+1)'(WIDTH - 1 - j));
  end
endmodule

// File: rtl/shf_carry.sv
module shf_carry
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  shf_kind_e        kind_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             carry_i,
  output logic             carry_o
);
  logic [AMT_W-1:0] comp_amt;
  logic [AMT_W-1:0] last_right;

  assign comp_amt   = AMT_W'(0) - amount_i;
  assign last_right = amount_i - AMT_W'(1);

  always_comb begin
    if (amount_i == '0)        carry_o = carry_i;
    else if (kind_i == SHF_LSL) carry_o = data_i[comp_amt];
    else                        carry_o = data_i[last_right];
  end
endmodule

// File: rtl/xbar_barrel_shifter.sv
module xbar_barrel_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [1:0]       kind_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  shf_kind_e        kind;
  logic [WIDTH-1:0] right_en;
  logic [WIDTH-1:0] left_en;
  logic [WIDTH-1:0] matrix_out;
  logic [WIDTH-1:0] fill;

  assign kind = shf_kind_e'(kind_i);

  shf_diag_decode #(.WIDTH(WIDTH)) i_decode (
    .kind_i    (kind),
    .amount_i  (amount_i),
    .right_en_o(right_en),
    .left_en_o (left_en)
  );

  shf_xbar_matrix #(.WIDTH(WIDTH)) i_matrix (
    .data_i    (operand_i),
    .right_en_i(right_en),
    .left_en_i (left_en),
    .data_o    (matrix_out)
  );

  shf_sign_fill #(.WIDTH(WIDTH)) i_fill (
    .asr_i   (kind == SHF_ASR),
    .sign_i  (operand_i[WIDTH-1]),
    .amount_i(amount_i),
    .fill_o  (fill)
  );

  shf_carry #(.WIDTH(WIDTH)) i_carry (
    .kind_i  (kind),
    .amount_i(amount_i),
    .data_i  (operand_i),
    .carry_i (carry_i),
    .carry_o (carry_o)
  );

  // sign fill overrides the zero-filled outputs
  assign result_o = matrix_out | fill;
endmodule

// File: rtl/xbar_barrel_shifter_chk.sv
module xbar_barrel_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [AMT_W-1:0] amount_i,
  input logic [1:0]       kind_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic [AMT_W-1:0] last_right;
  assign last_right = amount_i - AMT_W'(1);

  always_comb begin
    if (amount_i == '0) begin
      a_r2_zero_identity: assert (result_o == operand_i && carry_o == carry_i);
    end else begin
      if (kind_i == 2'b00) begin
        a_r1_lsl_low_zero: assert (result_o[0] == 1'b0);
      end
      if (kind_i == 2'b01) begin
        a_r3_lsr_top_zero: assert (result_o[WIDTH-1] == 1'b0);
      end
      if (kind_i == 2'b11) begin
        a_r5_ror_top_is_carry: assert (result_o[WIDTH-1] == carry_o);
      end
      if (kind_i != 2'b00) begin
        a_r7_right_carry: assert (carry_o == operand_i[last_right]);
      end
    end
    if (kind_i == 2'b10) begin
      a_r4_asr_sign_kept: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
    end
    if (kind_i == 2'b11) begin
      a_r5_ror_popcount: assert ($countones(result_o) == $countones(operand_i));
    end
  end
endmodule

bind xbar_barrel_shifter xbar_barrel_shifter_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_xbar_barrel_shifter.sv
`timescale 1ns/1ps
module test_xbar_barrel_shifter;
  logic        clk = 1'b0;
  logic [31:0] operand;
  logic [4:0]  amount;
  logic [1:0]  kind;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #2.5 clk = ~clk;

  xbar_barrel_shifter i_xbar_barrel_shifter (
    .operand_i(operand),
    .amount_i (amount),
    .kind_i   (kind),
    .carry_i  (carry_in),
    .result_o (result),
    .carry_o  (carry_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s kind=%0d amt=%0d op=%h actual=%h expected=%h",
               req, kind, amount, operand, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] op, input logic [1:0] k, input int n, input logic ci);
    logic [31:0] exp_r;
    logic        exp_c;
    string       req;
    operand  = op;
    kind     = k;
    amount   = 5'(n);
    carry_in = ci;
    #1;
    if (n == 0) begin
      exp_r = op;
      exp_c = ci;
    end else begin
      case (k)
        2'b00: exp_r = op << n;
        2'b01: exp_r = op >> n;
        2'b10: exp_r = 32'($signed(op) >>> n);
        default: exp_r = (op >> n) | (op << (32 - n));
      endcase
      exp_c = (k == 2'b00) ? op[32-n] : op[n-1];
    end
    case (k)
      2'b00: req = "R1";
      2'b01: req = "R3";
      2'b10: req = "R4";
      default: req = "R5";
    endcase
    if (n == 0) req = "R2";
    check(req, result, exp_r);
    if (n == 0) req = "R2";
    else req = (k == 2'b00) ? "R6" : "R7";
    check(req, {31'b0, carry_out}, {31'b0, exp_c});
  endtask

  initial begin
    logic [31:0] ops [24];
    ops[0] = 32'h0000_0000;
    ops[1] = 32'hFFFF_FFFF;
    ops[2] = 32'h8000_0000;
    ops[3] = 32'h0000_0001;
    ops[4] = 32'h7FFF_FFFF;
    ops[5] = 32'hA5A5_A5A5;
    for (int i = 6; i < 24; i++) ops[i] = $urandom;

    // R8: outputs valid before the first clock edge
    operand = 32'h8000_0001; kind = 2'b11; amount = 5'd1; carry_in = 1'b0;
    #0.5;
    check("R8", result, 32'hC000_0000);
    check("R8", {31'b0, carry_out}, 32'd1);
    // all-zero inputs: identity, carry passes through (R2)
    operand = '0; kind = 2'b00; amount = '0; carry_in = 1'b0;
    #1;
    check("R2", result, 32'h0);
    check("R2", {31'b0, carry_out}, 32'd0);

    for (int o = 0; o < 24; o++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 32; n++)
          apply(ops[o], 2'(k), n, 1'((o + n + k) & 1));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule